// File: doc/BRIEF.md
# Serial Watchdog Timeout Control Port

This block is the register side of a supervisory watchdog. A host reaches it over a four-wire serial link in clock mode 0 (clock idles low, data sampled on the rising edge, shifted out on the falling edge, most significant bit first). One-byte instructions arm or disarm a change latch, write a new timeout selection, or read the current selection back. The two timeout bits drive the watchdog counter directly through `wd_sel`.

A write is accepted only under three conditions. The change latch must be armed. Chip select must rise right after the sixteenth bit. The reserved bits of the data byte must be zero. An accepted write starts a timed busy window that models a nonvolatile store. During that window a read answers with all ones, and instructions that change state are dropped. When the window closes, the change latch clears itself.

All serial pins are oversampled by the system clock `clk`. The serial clock must therefore be several times slower than `clk`.

Top module: `spi_wdt_ctrl`

## Requirements
- R1: After reset, `wd_sel` equals parameter `RESET_WD` (default 2'b00), the change latch is clear and `spi_miso_oe` is low.
- R2: After reset, no instruction is decoded until `spi_cs_n` has been seen going high and then low; bits clocked in a frame that was already low at reset are ignored.
- R3: Opcode 06h arms the change latch and opcode 04h disarms it. The latch acts once the eighth bit has been sampled.
- R4: Opcode 01h followed by one data byte loads data bit 4 into `wd_sel[1]` and data bit 3 into `wd_sel[0]`. This happens only if the latch is armed and chip select rises after exactly 16 sampled bits; a frame of any other length changes nothing.
- R5: A write whose data byte has any bit set under mask E7h is discarded, and the register keeps its old value.
- R6: Opcode 05h returns the byte {3'b000, wd_sel[1], wd_sel[0], 3'b000} MSB first. The first bit appears on the falling edge after the eighth bit. `spi_miso_oe` is high only in such a read data phase, and low whenever chip select is high.
- R7: An accepted write starts a busy window of `WR_CYCLES` clock cycles, counted from the chip-select rise that ends the frame. A read whose data phase begins inside that window returns FFh.
- R8: The change latch clears when the busy window ends, so a second write needs a new 06h.
- R9: Opcodes 06h, 04h and 01h received while the busy window is open are ignored.
- R10: An opcode other than 06h, 04h, 01h or 05h makes the block ignore the rest of the frame until chip select rises.
- R11: `wd_sel` changes only on the chip-select rise that ends an accepted write, and it then holds the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| wd_sel | output | 2 | Timeout selection to the watchdog counter |

## Verification
Well-formed writes with the latch armed show that the data bits land in `wd_sel` and are read back correctly. The same writes are then repeated under conditions that must reject them: no latch, a latch that was disarmed, a latch cleared by the end of an earlier write, reserved bits set, and frames of 12 or 17 bits. Each rejection is told apart from a correct write by reading back a value that differs from the one the rejected write carried. Reads placed inside the busy window, a second write sent during that window, an unknown opcode followed by 06h in the same frame, and a reset released with chip select already low separate R2, R7, R9 and R10 from ordinary decoding.

// File: rtl/spi_wdt_ctrl.sv
module spi_wdt_ctrl #(
  parameter int         WR_CYCLES = 1_250_000,
  parameter logic [1:0] RESET_WD  = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic [1:0] wd_sel
);

  localparam int         TW       = $clog2(WR_CYCLES + 1);
  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_DISARM= 8'h04;
  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h05;
  localparam logic [7:0] RSV_MASK = 8'hE7;

  typedef enum logic [1:0] {M_CMD, M_WR, M_RD, M_IGN} mode_t;

  logic [2:0]    sck_sr, cs_sr;
  logic [1:0]    mosi_sr;
  logic          in_frame, wel, busy, oe;
  mode_t         mode;
  logic [4:0]    bit_cnt;
  logic [7:0]    rx_sr, tx_sr;
  logic [TW-1:0] timer;
  logic [1:0]    wd_q;

  wire       sck_rise = sck_sr[1] & ~sck_sr[2];
  wire       sck_fall = ~sck_sr[1] & sck_sr[2];
  wire       cs_fall  = ~cs_sr[1] & cs_sr[2];
  wire       cs_rise  = cs_sr[1] & ~cs_sr[2];
  wire [7:0] rx_byte  = {rx_sr[6:0], mosi_sr[1]};
  wire       wr_ok    = in_frame && mode == M_WR && bit_cnt == 5'd16 &&
                        wel && !busy && (rx_sr & RSV_MASK) == 8'h00;

  assign spi_miso    = tx_sr[7];
  assign spi_miso_oe = oe;
  assign wd_sel      = wd_q;

  // Synchronizers reset low so a chip select already low at reset never looks like a fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr  <= '0;
      cs_sr   <= '0;
      mosi_sr <= '0;
    end else begin
      sck_sr  <= {sck_sr[1:0], spi_sck};
      cs_sr   <= {cs_sr[1:0], spi_cs_n};
      mosi_sr <= {mosi_sr[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      mode     <= M_IGN;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      oe       <= 1'b0;
      wel      <= 1'b0;
      busy     <= 1'b0;
      timer    <= '0;
      wd_q     <= RESET_WD;
    end else begin
      if (busy) begin
        if (timer == TW'(WR_CYCLES - 1)) begin
          busy  <= 1'b0;
          wel   <= 1'b0;
          timer <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end

      if (cs_fall) begin
        in_frame <= 1'b1;
        mode     <= M_CMD;
        bit_cnt  <= '0;
      end else if (cs_rise) begin
        in_frame <= 1'b0;
        oe       <= 1'b0;
        if (wr_ok) begin
          wd_q  <= rx_sr[4:3];
          busy  <= 1'b1;
          timer <= '0;
        end
      end else if (in_frame) begin
        if (sck_rise) begin
          rx_sr <= rx_byte;
          if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
          if (mode == M_CMD && bit_cnt == 5'd7) begin
            case (rx_byte)
              OP_ARM: begin
                if (!busy) wel <= 1'b1;
                mode <= M_IGN;
              end
              OP_DISARM: begin
                if (!busy) wel <= 1'b0;
                mode <= M_IGN;
              end
              OP_WRITE: mode <= busy ? M_IGN : M_WR;
              OP_READ:  mode <= M_RD;
              default:  mode <= M_IGN;
            endcase
          end
        end
        if (sck_fall && mode == M_RD) begin
          if (!oe) begin
            oe    <= 1'b1;
            tx_sr <= busy ? 8'hFF : {3'b000, wd_q, 3'b000};
          end else begin
            tx_sr <= {tx_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

  assert_oe_off_deselected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sr[1] && cs_sr[2]) |-> !spi_miso_oe);

  assert_busy_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_miso_oe) && $past(busy)) |-> spi_miso);

  assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (timer < TW'(WR_CYCLES)));

  assert_latch_clear_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  assert_sel_change_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_sel) |-> (busy && !$past(busy)));

endmodule

// File: tb/spi_wdt_ctrl_bench.sv
module spi_wdt_ctrl_bench;

  localparam int WR   = 2000;
  localparam int HALF = 10;
  localparam int NV   = 20;

  // {kind, byte1, byte2, expected}: 1 = one-byte command, 2 = 16-bit write, 3 = read, 4 = wait out busy
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'h03_05_00_00,  // R1 reset value
    32'h02_01_08_00,  // R4 write without armed latch
    32'h03_05_00_00,
    32'h01_06_00_00,  // R3 arm
    32'h02_01_18_00,  // R4 valid write
    32'h04_00_00_00,
    32'h03_05_00_18,
    32'h02_01_08_00,  // R8 latch cleared by completed write
    32'h03_05_00_18,
    32'h01_06_00_00,  // R3 arm then disarm
    32'h01_04_00_00,
    32'h02_01_08_00,
    32'h03_05_00_18,
    32'h01_06_00_00,  // R5 reserved bit 2 set
    32'h02_01_0C_00,
    32'h03_05_00_18,
    32'h02_01_10_00,  // latch still armed after the discarded write
    32'h04_00_00_00,
    32'h03_05_00_10,
    32'h03_05_00_10
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso, miso_oe;
  logic [1:0] wd_sel;

  int nchk = 0;
  int nfail = 0;
  int cycles = 0;
  logic oe_seen;
  logic [31:0] rd;

  spi_wdt_ctrl #(.WR_CYCLES(WR), .RESET_WD(2'b00)) u_spi_wdt_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .wd_sel(wd_sel)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired: actual=%0d cycles expected=finish", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nb, input logic [31:0] dout, input bit cs_held, output logic [31:0] din);
    din = '0;
    oe_seen = 1'b0;
    if (!cs_held) begin
      cs_n = 1'b0;
      hold(HALF);
    end
    for (int i = 0; i < nb; i++) begin
      mosi = dout[nb-1-i];
      hold(HALF);
      din = {din[30:0], miso};
      oe_seen = oe_seen | miso_oe;
      sck = 1'b1;
      hold(HALF);
      sck = 1'b0;
    end
    hold(HALF);
    cs_n = 1'b1;
    hold(2 * HALF);
  endtask

  task automatic rd_reg(output logic [31:0] val);
    xfer(16, 32'h0500, 1'b0, val);
    val = {24'h0, val[7:0]};
  endtask

  initial begin
    logic [31:0] d;
    hold(5);
    chk("R1 miso_oe in reset", {31'h0, miso_oe}, 32'h0);
    rst_n = 1'b1;
    hold(5);
    chk("R1 wd_sel after reset", {30'h0, wd_sel}, 32'h0);
    chk("R1 miso_oe after reset", {31'h0, miso_oe}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][31:24])
        8'h01: begin
          xfer(8, {24'h0, VEC[i][23:16]}, 1'b0, d);
          chk($sformatf("R6 vec %0d no output enable on command", i), {31'h0, oe_seen}, 32'h0);
        end
        8'h02: xfer(16, {16'h0, VEC[i][23:8]}, 1'b0, d);
        8'h03: begin
          rd_reg(rd);
          chk($sformatf("R3/R4/R5/R6/R8 vec %0d read", i), rd, {24'h0, VEC[i][7:0]});
          chk($sformatf("R6 vec %0d output enable in read", i), {31'h0, oe_seen}, 32'h1);
          chk($sformatf("R11 vec %0d wd_sel", i), {30'h0, wd_sel}, {30'h0, VEC[i][4:3]});
          chk($sformatf("R6 vec %0d oe after deselect", i), {31'h0, miso_oe}, 32'h0);
        end
        default: hold(WR + 100);
      endcase
    end

    // R7 read inside the busy window, R9 write during busy ignored
    xfer(8, 32'h06, 1'b0, d);
    xfer(16, 32'h0108, 1'b0, d);
    rd_reg(rd);
    chk("R7 read during busy", rd, 32'hFF);
    xfer(16, 32'h0118, 1'b0, d);
    xfer(8, 32'h06, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R9 write during busy ignored", rd, 32'h08);
    chk("R11 wd_sel after busy", {30'h0, wd_sel}, 32'h1);
    xfer(16, 32'h0118, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R9 arm during busy ignored", rd, 32'h08);

    // R4 frame length must be exactly 16 bits
    xfer(8, 32'h06, 1'b0, d);
    xfer(17, 32'h00231, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R4 17-bit frame discarded", rd, 32'h08);
    xfer(12, 32'h011, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R4 12-bit frame discarded", rd, 32'h08);
    xfer(16, 32'h0100, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R4 latch kept through short and long frames", rd, 32'h00);

    // R10 unknown opcode swallows the rest of the frame
    xfer(16, 32'hAA06, 1'b0, d);
    xfer(16, 32'h0118, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R10 unknown opcode ignores trailing arm", rd, 32'h00);

    // R2 frame already low at reset is not decoded
    rst_n = 1'b0;
    cs_n = 1'b0;
    hold(5);
    rst_n = 1'b1;
    hold(5);
    xfer(8, 32'h06, 1'b1, d);
    xfer(16, 32'h0118, 1'b0, d);
    hold(WR + 100);
    rd_reg(rd);
    chk("R2 arm in frame open at reset ignored", rd, 32'h00);
    chk("R2 wd_sel unchanged", {30'h0, wd_sel}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule